// File: doc/BRIEF.md
# Bit-Serial SIMD Macroinstruction Sequencer

This block sits between a host processor and a row of simple memory-column processing elements. The processing elements store every vector element down a memory column, one bit per row, and have two one-bit registers, X and Y. The host sends short macroinstructions such as "add two n-bit vectors" through a valid/ready command port. The block queues them and expands each one into a stream of native instructions. The stream runs on its own, so the host is free to do other work while it plays out.

Each native instruction has a read row, an 8-bit ALU truth table, a destination (memory, X, Y or the write-enable latch), a write row for memory results, and communication control bits. The truth table is indexed by {M, X, Y}, where M is the memory bit read from the row; bit k of the opcode is the result for index k. Every native instruction takes two cycles at the output: first an address phase that presents the read row, then an operation phase that presents the opcode, destination, write row and communication bits.

The block also has a direct path. Through it the host writes one native instruction that is issued unchanged, but only while the sequencer is idle, so direct and expanded instructions never interleave.

Top module: `pe_macro_seq`

## Requirements
- R1: After reset, busy is low, cmd_ready is high, and pe_addr_vld and pe_op_vld are both low.
- R2: Every native instruction appears as one cycle with pe_addr_vld high, followed in the very next cycle by one cycle with pe_op_vld high. The two strobes are never high together.
- R3: The command queue holds 4 macroinstructions. cmd_ready is low exactly while 4 are waiting. Commands are expanded in the order they were accepted.
- R4: An add (cmd_kind 1) first issues (row A, opcode 0x00, dest Y). Then, for each bit i from 0 upward, it issues three instructions: (row A+i, 0xF0, dest X), then (row B+i, 0x96, dest memory, write row D+i), then (row B+i, 0xE8, dest Y).
- R5: A copy (cmd_kind 0) issues one instruction per bit i: (row A+i, 0xF0, dest memory, write row D+i).
- R6: AND, OR and XOR (cmd_kind 2, 3, 4) issue two instructions per bit i: (row A+i, 0xF0, dest X), then (row B+i, opcode 0xC0, 0xFC or 0x3C respectively, dest memory, write row D+i).
- R7: The width field cmd_nlast holds n-1, so one command covers 1 to 16 bits. Row arithmetic wraps modulo 256.
- R8: cmd_kind values 5, 6 and 7 are accepted and consumed, and they issue no native instruction.
- R9: A dir_wr pulse while busy is low is issued as exactly one native instruction with its fields unchanged. A dir_wr pulse while busy is high is dropped.
- R10: busy goes high in the cycle after a command is accepted. It stays high until the last operation phase of the queued work has been issued.
- Destination codes: 0 memory, 1 X, 2 Y, 3 write enable. The write row is 0 and comm is 0 for every expanded instruction whose destination is not memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Macroinstruction offered |
| cmd_ready | output | 1 | Queue can accept a macroinstruction |
| cmd_kind | input | 3 | 0 copy, 1 add, 2 and, 3 or, 4 xor, others ignored |
| cmd_src_a | input | 8 | Base row of operand A |
| cmd_src_b | input | 8 | Base row of operand B |
| cmd_dst | input | 8 | Base row of the result |
| cmd_nlast | input | 4 | Operand width minus one |
| dir_wr | input | 1 | Direct native-instruction write strobe |
| dir_row | input | 8 | Direct read row |
| dir_op | input | 8 | Direct truth-table opcode |
| dir_dst | input | 2 | Direct destination code |
| dir_wrow | input | 8 | Direct write row |
| dir_comm | input | 2 | Direct communication controls |
| busy | output | 1 | Queue non-empty, expanding or issuing |
| pe_addr_vld | output | 1 | Address phase strobe |
| pe_addr | output | 8 | Read row of the current instruction |
| pe_op_vld | output | 1 | Operation phase strobe |
| pe_op | output | 8 | Truth-table opcode |
| pe_dst | output | 2 | Destination code |
| pe_wrow | output | 8 | Memory write row |
| pe_comm | output | 2 | Communication controls |

## Verification
A bad bit or step counter in the expander shows up at the very next address phase, as a wrong row or a wrong opcode, so it appears within two cycles of the fault. A corrupted queue pointer shows up when the next command starts: instructions arrive out of order, or cmd_ready sticks low or high. A phase-tracking fault in the issuer shows up at once as an operation strobe with no address strobe before it. A wrong busy term shows up as a dropped or leaked direct write, or as the bench waiting on a busy flag that never falls.

// File: rtl/seq_pkg.sv
package seq_pkg;
   localparam int KIND_W = 3;
   localparam int OP_W   = 8;
   localparam int DST_W  = 2;

   localparam logic [KIND_W-1:0] K_COPY = 3'd0;
   localparam logic [KIND_W-1:0] K_ADD  = 3'd1;
   localparam logic [KIND_W-1:0] K_AND  = 3'd2;
   localparam logic [KIND_W-1:0] K_OR   = 3'd3;
   localparam logic [KIND_W-1:0] K_XOR  = 3'd4;

   localparam logic [DST_W-1:0] D_MEM = 2'd0;
   localparam logic [DST_W-1:0] D_X   = 2'd1;
   localparam logic [DST_W-1:0] D_Y   = 2'd2;

   // truth tables indexed by {M,X,Y}
   localparam logic [OP_W-1:0] OP_ZERO = 8'h00;
   localparam logic [OP_W-1:0] OP_PASS = 8'hF0;
   localparam logic [OP_W-1:0] OP_SUM  = 8'h96;
   localparam logic [OP_W-1:0] OP_MAJ  = 8'hE8;
   localparam logic [OP_W-1:0] OP_AND  = 8'hC0;
   localparam logic [OP_W-1:0] OP_OR   = 8'hFC;
   localparam logic [OP_W-1:0] OP_XOR  = 8'h3C;

   typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_OPER} phase_t;

   function automatic logic kind_known(input logic [KIND_W-1:0] k);
      return k <= K_XOR;
   endfunction

   function automatic logic [1:0] last_step(input logic [KIND_W-1:0] k);
      case (k)
         K_ADD:   return 2'd2;
         K_COPY:  return 2'd0;
         default: return 2'd1;
      endcase
   endfunction
endpackage

// File: rtl/seq_cmd_fifo.sv
module seq_cmd_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] din,
   input  logic         rd_en,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [CNT_W-1:0] cnt;

   assign full  = (cnt == CNT_W'(DEPTH));
   assign empty = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else
         cnt <= cnt + CNT_W'(wr_en && !full) - CNT_W'(rd_en && !empty);
   end

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("seq_cmd_fifo: DEPTH must be at least 1");
      end
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot;
         always_ff @(posedge clk) begin
            if (wr_en && !full) slot <= din;
         end
         assign dout = slot;
      end else begin : g_ring
         logic [W-1:0]     mem [DEPTH];
         logic [PTR_W-1:0] wp, rp;
         function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
            return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
         endfunction
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wp <= '0;
               rp <= '0;
            end else begin
               if (wr_en && !full)  wp <= bump(wp);
               if (rd_en && !empty) rp <= bump(rp);
            end
         end
         always_ff @(posedge clk) begin
            if (wr_en && !full) mem[wp] <= din;
         end
         assign dout = mem[rp];
      end
   endgenerate

   assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && !rd_en) |=> full);
endmodule

// File: rtl/seq_expand.sv
module seq_expand
   import seq_pkg::*;
#(
   parameter int ROW_W  = 8,
   parameter int NB_W   = 4,
   parameter int COMM_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_avail,
   input  logic [KIND_W-1:0] cmd_kind,
   input  logic [ROW_W-1:0]  cmd_a,
   input  logic [ROW_W-1:0]  cmd_b,
   input  logic [ROW_W-1:0]  cmd_d,
   input  logic [NB_W-1:0]   cmd_nlast,
   output logic              cmd_pop,
   input  logic              take,
   output logic              active,
   output logic              ins_vld,
   output logic [ROW_W-1:0]  ins_row,
   output logic [OP_W-1:0]   ins_op,
   output logic [DST_W-1:0]  ins_dst,
   output logic [ROW_W-1:0]  ins_wrow,
   output logic [COMM_W-1:0] ins_comm
);
   logic [KIND_W-1:0] kind;
   logic [ROW_W-1:0]  ra, rb, rd;
   logic [NB_W-1:0]   nl, bi;
   logic [1:0]        st;
   logic              clr;
   logic [ROW_W-1:0]  ra_i, rb_i, rd_i;

   assign cmd_pop = !active && cmd_avail;
   assign ra_i = ra + ROW_W'(bi);
   assign rb_i = rb + ROW_W'(bi);
   assign rd_i = rd + ROW_W'(bi);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         clr    <= 1'b0;
         st     <= '0;
         bi     <= '0;
         kind   <= '0;
         ra     <= '0;
         rb     <= '0;
         rd     <= '0;
         nl     <= '0;
      end else if (cmd_pop) begin
         active <= kind_known(cmd_kind);
         clr    <= (cmd_kind == K_ADD);
         kind   <= cmd_kind;
         ra     <= cmd_a;
         rb     <= cmd_b;
         rd     <= cmd_d;
         nl     <= cmd_nlast;
         bi     <= '0;
         st     <= '0;
      end else if (active && take) begin
         if (clr) begin
            clr <= 1'b0;
         end else if (st == last_step(kind)) begin
            st <= '0;
            if (bi == nl) active <= 1'b0;
            else          bi     <= bi + 1'b1;
         end else begin
            st <= st + 1'b1;
         end
      end
   end

   always_comb begin
      ins_vld  = active;
      ins_row  = ra_i;
      ins_op   = OP_PASS;
      ins_dst  = D_X;
      ins_wrow = '0;
      ins_comm = '0;
      case (kind)
         K_ADD: begin
            if (clr) begin
               ins_row = ra;
               ins_op  = OP_ZERO;
               ins_dst = D_Y;
            end else if (st == 2'd1) begin
               ins_row  = rb_i;
               ins_op   = OP_SUM;
               ins_dst  = D_MEM;
               ins_wrow = rd_i;
            end else if (st == 2'd2) begin
               ins_row = rb_i;
               ins_op  = OP_MAJ;
               ins_dst = D_Y;
            end
         end
         K_COPY: begin
            ins_dst  = D_MEM;
            ins_wrow = rd_i;
         end
         default: begin
            if (st != 2'd0) begin
               ins_row  = rb_i;
               ins_dst  = D_MEM;
               ins_wrow = rd_i;
               ins_op   = (kind == K_AND) ? OP_AND :
                          (kind == K_OR)  ? OP_OR  : OP_XOR;
            end
         end
      endcase
   end

   assert_bit_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (bi <= nl));
   assert_start_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> (bi == '0 && st == '0 && (clr == (kind == K_ADD))));
   assert_unknown_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_pop && !kind_known(cmd_kind)) |=> !active);
endmodule

// File: rtl/seq_issue.sv
module seq_issue
   import seq_pkg::*;
#(
   parameter int ROW_W  = 8,
   parameter int COMM_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [ROW_W-1:0]  in_row,
   input  logic [OP_W-1:0]   in_op,
   input  logic [DST_W-1:0]  in_dst,
   input  logic [ROW_W-1:0]  in_wrow,
   input  logic [COMM_W-1:0] in_comm,
   output logic              in_take,
   output logic              in_flight,
   output logic              pe_addr_vld,
   output logic [ROW_W-1:0]  pe_addr,
   output logic              pe_op_vld,
   output logic [OP_W-1:0]   pe_op,
   output logic [DST_W-1:0]  pe_dst,
   output logic [ROW_W-1:0]  pe_wrow,
   output logic [COMM_W-1:0] pe_comm
);
   phase_t ph;

   assign in_take     = in_vld && (ph != PH_ADDR);
   assign in_flight   = (ph != PH_IDLE);
   assign pe_addr_vld = (ph == PH_ADDR);
   assign pe_op_vld   = (ph == PH_OPER);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph <= PH_IDLE;
      end else begin
         case (ph)
            PH_ADDR: ph <= PH_OPER;
            default: ph <= in_take ? PH_ADDR : PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pe_addr <= '0;
         pe_op   <= '0;
         pe_dst  <= '0;
         pe_wrow <= '0;
         pe_comm <= '0;
      end else if (in_take) begin
         pe_addr <= in_row;
         pe_op   <= in_op;
         pe_dst  <= in_dst;
         pe_wrow <= in_wrow;
         pe_comm <= in_comm;
      end
   end

   assert_addr_then_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pe_addr_vld |=> pe_op_vld);
   assert_op_after_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pe_op_vld |-> $past(pe_addr_vld));
   assert_fields_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pe_op_vld |-> $stable(pe_addr));
endmodule

// File: rtl/pe_macro_seq.sv
module pe_macro_seq
   import seq_pkg::*;
#(
   parameter int ROW_W      = 8,
   parameter int NB_W       = 4,
   parameter int COMM_W     = 2,
   parameter int FIFO_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [2:0]        cmd_kind,
   input  logic [ROW_W-1:0]  cmd_src_a,
   input  logic [ROW_W-1:0]  cmd_src_b,
   input  logic [ROW_W-1:0]  cmd_dst,
   input  logic [NB_W-1:0]   cmd_nlast,
   input  logic              dir_wr,
   input  logic [ROW_W-1:0]  dir_row,
   input  logic [7:0]        dir_op,
   input  logic [1:0]        dir_dst,
   input  logic [ROW_W-1:0]  dir_wrow,
   input  logic [COMM_W-1:0] dir_comm,
   output logic              busy,
   output logic              pe_addr_vld,
   output logic [ROW_W-1:0]  pe_addr,
   output logic              pe_op_vld,
   output logic [7:0]        pe_op,
   output logic [1:0]        pe_dst,
   output logic [ROW_W-1:0]  pe_wrow,
   output logic [COMM_W-1:0] pe_comm
);
   localparam int CMD_W = KIND_W + 3 * ROW_W + NB_W;

   generate
      if (NB_W < 1 || ROW_W < 1 || COMM_W < 1) begin : g_bad_width
         $error("pe_macro_seq: widths must be positive");
      end
      if (FIFO_DEPTH < 1) begin : g_bad_depth
         $error("pe_macro_seq: FIFO_DEPTH must be at least 1");
      end
   endgenerate

   logic [CMD_W-1:0] q_din, q_dout;
   logic q_full, q_empty, q_pop;

   logic [KIND_W-1:0] q_kind;
   logic [ROW_W-1:0]  q_a, q_b, q_d;
   logic [NB_W-1:0]   q_nl;

   logic              x_active, x_vld, x_take;
   logic [ROW_W-1:0]  x_row, x_wrow;
   logic [OP_W-1:0]   x_op;
   logic [DST_W-1:0]  x_dst;
   logic [COMM_W-1:0] x_comm;

   logic              i_vld, i_take, i_flight, dir_go;
   logic [ROW_W-1:0]  i_row, i_wrow;
   logic [OP_W-1:0]   i_op;
   logic [DST_W-1:0]  i_dst;
   logic [COMM_W-1:0] i_comm;

   assign cmd_ready = !q_full;
   assign q_din = {cmd_kind, cmd_src_a, cmd_src_b, cmd_dst, cmd_nlast};
   assign {q_kind, q_a, q_b, q_d, q_nl} = q_dout;
   assign busy = !q_empty || x_active || i_flight;

   seq_cmd_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (cmd_valid),
      .din   (q_din),
      .rd_en (q_pop),
      .dout  (q_dout),
      .full  (q_full),
      .empty (q_empty)
   );

   seq_expand #(.ROW_W(ROW_W), .NB_W(NB_W), .COMM_W(COMM_W)) u_exp (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_avail (!q_empty),
      .cmd_kind  (q_kind),
      .cmd_a     (q_a),
      .cmd_b     (q_b),
      .cmd_d     (q_d),
      .cmd_nlast (q_nl),
      .cmd_pop   (q_pop),
      .take      (x_take),
      .active    (x_active),
      .ins_vld   (x_vld),
      .ins_row   (x_row),
      .ins_op    (x_op),
      .ins_dst   (x_dst),
      .ins_wrow  (x_wrow),
      .ins_comm  (x_comm)
   );

   // direct writes only enter an idle sequencer, keeping issue order intact
   assign dir_go = dir_wr && !busy;
   assign i_vld  = dir_go || x_vld;
   assign i_row  = dir_go ? dir_row  : x_row;
   assign i_op   = dir_go ? dir_op   : x_op;
   assign i_dst  = dir_go ? dir_dst  : x_dst;
   assign i_wrow = dir_go ? dir_wrow : x_wrow;
   assign i_comm = dir_go ? dir_comm : x_comm;
   assign x_take = i_take && !dir_go;

   seq_issue #(.ROW_W(ROW_W), .COMM_W(COMM_W)) u_iss (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_vld      (i_vld),
      .in_row      (i_row),
      .in_op       (i_op),
      .in_dst      (i_dst),
      .in_wrow     (i_wrow),
      .in_comm     (i_comm),
      .in_take     (i_take),
      .in_flight   (i_flight),
      .pe_addr_vld (pe_addr_vld),
      .pe_addr     (pe_addr),
      .pe_op_vld   (pe_op_vld),
      .pe_op       (pe_op),
      .pe_dst      (pe_dst),
      .pe_wrow     (pe_wrow),
      .pe_comm     (pe_comm)
   );

   assert_busy_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> busy);
   assert_dir_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dir_go |-> !x_vld);
endmodule

// File: tb/sim_pe_macro_seq.sv
`timescale 1ns/1ps
module sim_pe_macro_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       cmd_valid = 0, cmd_ready;
   logic [2:0] cmd_kind = 0;
   logic [7:0] cmd_src_a = 0, cmd_src_b = 0, cmd_dst = 0;
   logic [3:0] cmd_nlast = 0;
   logic       dir_wr = 0;
   logic [7:0] dir_row = 0, dir_op = 0, dir_wrow = 0;
   logic [1:0] dir_dst = 0, dir_comm = 0;
   logic       busy, pe_addr_vld, pe_op_vld;
   logic [7:0] pe_addr, pe_op, pe_wrow;
   logic [1:0] pe_dst, pe_comm;

   pe_macro_seq u0 (.*);

   int checks = 0, fails = 0;
   int exp_row[1024], exp_op[1024], exp_dst[1024], exp_wr[1024], exp_cm[1024];
   int act_row[1024], act_op[1024], act_dst[1024], act_wr[1024], act_cm[1024];
   int exp_n = 0, act_n = 0;
   logic pend = 0;
   logic timeout = 0;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic void add_exp(input int r, input int op, input int d, input int w, input int c);
      exp_row[exp_n] = r & 255; exp_op[exp_n] = op; exp_dst[exp_n] = d;
      exp_wr[exp_n] = w & 255; exp_cm[exp_n] = c;
      exp_n++;
   endfunction

   // expected expansion, computed from R4..R8
   function automatic void model_cmd(input int k, input int a, input int b, input int d, input int nl);
      if (k == 1) add_exp(a, 8'h00, 2, 0, 0);
      for (int i = 0; i <= nl; i++) begin
         case (k)
            0: add_exp(a + i, 8'hF0, 0, d + i, 0);
            1: begin
               add_exp(a + i, 8'hF0, 1, 0, 0);
               add_exp(b + i, 8'h96, 0, d + i, 0);
               add_exp(b + i, 8'hE8, 2, 0, 0);
            end
            2, 3, 4: begin
               add_exp(a + i, 8'hF0, 1, 0, 0);
               add_exp(b + i, (k == 2) ? 8'hC0 : (k == 3) ? 8'hFC : 8'h3C, 0, d + i, 0);
            end
            default: ;
         endcase
      end
   endfunction

   // stream monitor, sampling away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (pe_addr_vld && pe_op_vld) check(0, "R2 both strobes", 1, 0);
         if (pe_op_vld) begin
            check(pend, "R2 op without address", 0, 1);
            if (act_n < 1024) begin
               act_op[act_n] = pe_op; act_dst[act_n] = pe_dst;
               act_wr[act_n] = pe_wrow; act_cm[act_n] = pe_comm;
               act_n++;
            end
         end
         if (pe_addr_vld && act_n < 1024) act_row[act_n] = pe_addr;
         pend = pe_addr_vld;
      end
   end

   task automatic push(input int k, input int a, input int b, input int d, input int nl);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_kind = 3'(k); cmd_src_a = 8'(a); cmd_src_b = 8'(b); cmd_dst = 8'(d);
      cmd_nlast = 4'(nl); cmd_valid = 1;
      model_cmd(k, a, b, d, nl);
      @(negedge clk);
      cmd_valid = 0;
   endtask

   task automatic dir_write(input int r, input int op, input int d, input int w, input int c);
      @(negedge clk);
      dir_row = 8'(r); dir_op = 8'(op); dir_dst = 2'(d); dir_wrow = 8'(w); dir_comm = 2'(c);
      dir_wr = 1;
      @(negedge clk);
      dir_wr = 0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic compare(input string tag);
      check(act_n == exp_n, {tag, " count"}, act_n, exp_n);
      for (int j = 0; j < exp_n && j < act_n; j++) begin
         check(act_row[j] == exp_row[j], {tag, " row"}, act_row[j], exp_row[j]);
         check(act_op[j] == exp_op[j], {tag, " opcode"}, act_op[j], exp_op[j]);
         check(act_dst[j] == exp_dst[j], {tag, " dest"}, act_dst[j], exp_dst[j]);
         check(act_wr[j] == exp_wr[j] && act_cm[j] == exp_cm[j], {tag, " wrow/comm"},
               act_wr[j] * 256 + act_cm[j], exp_wr[j] * 256 + exp_cm[j]);
      end
      exp_n = 0;
      act_n = 0;
   endtask

   task automatic run_all();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1
      check(!busy && cmd_ready && !pe_addr_vld && !pe_op_vld, "R1 reset state",
            {busy, cmd_ready, pe_addr_vld, pe_op_vld}, 4'b0100);

      // R4, R10: one-bit add, busy after accept
      @(negedge clk);
      cmd_kind = 1; cmd_src_a = 10; cmd_src_b = 20; cmd_dst = 30; cmd_nlast = 0; cmd_valid = 1;
      model_cmd(1, 10, 20, 30, 0);
      @(negedge clk);
      cmd_valid = 0;
      check(busy, "R10 busy after accept", busy, 1);
      wait_idle();
      check(!busy, "R10 busy falls when done", busy, 0);
      compare("R4 add 1 bit");

      // R7: wrap of rows, widest add
      push(1, 254, 250, 252, 15);
      wait_idle();
      compare("R7 add wrap 16 bits");

      // R5, R6
      push(0, 5, 0, 100, 7);
      push(2, 1, 2, 3, 3);
      push(3, 40, 50, 60, 2);
      push(4, 200, 201, 202, 1);
      wait_idle();
      compare("R5 R6 copy and logic");

      // R3: fill the queue behind a long add; R9: dropped direct write
      push(1, 0, 64, 128, 15);
      push(0, 1, 0, 11, 0);
      push(0, 2, 0, 12, 0);
      push(0, 3, 0, 13, 0);
      push(0, 4, 0, 14, 0);
      check(!cmd_ready, "R3 ready low when 4 queued", cmd_ready, 0);
      check(busy, "R9 busy during direct attempt", busy, 1);
      dir_write(77, 8'h5A, 3, 9, 3);
      wait_idle();
      compare("R3 R9 order and ignored direct");

      // R8: unknown kinds between copies
      push(0, 9, 0, 19, 0);
      push(6, 1, 1, 1, 5);
      push(7, 2, 2, 2, 3);
      push(5, 3, 3, 3, 1);
      push(0, 8, 0, 18, 0);
      wait_idle();
      compare("R8 unknown kinds");
      check(cmd_ready && !busy, "R8 idle after unknowns", {cmd_ready, busy}, 2'b10);

      // R9: accepted direct write
      dir_write(77, 8'h5A, 3, 9, 3);
      add_exp(77, 8'h5A, 3, 9, 3);
      wait_idle();
      compare("R9 direct accepted");

      // constrained random batches
      for (int batch = 0; batch < 4; batch++) begin
         for (int c = 0; c < 6; c++) begin
            push(int'($urandom_range(7)), int'($urandom_range(255)), int'($urandom_range(255)),
                 int'($urandom_range(255)), int'($urandom_range(15)));
         end
         wait_idle();
         compare("R3 R4 R5 R6 R8 random");
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            timeout = 1;
         end
      join_any
      disable fork;
      if (timeout) check(0, "watchdog", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule